// File: doc/BRIEF.md
# Three-Phase PWM Generator with Fractional Duty Dithering

This block drives three half-bridge phases of a motor inverter from one shared period counter. Each phase receives a duty command split into an integer count and an 8-bit fraction. A first-order sigma-delta accumulator per phase turns the fraction into an occasional extra count. The compare value applied in a given period is therefore either the integer or the integer plus one. Over many periods the average resolves to well below one clock count, and the number of switching edges per period does not change. The counter can run sawtooth (edge-aligned) or triangle (centre-aligned).

Each phase drives a complementary high-side and low-side pair with a programmable dead band. A one-clock strobe for the current-sense converter is generated once per period at a programmable counter value. This lets sampling be placed away from the switching edges. Commands are taken only at the end of each period, so no period is cut short or glitched. With an 80 MHz clock and a 12-bit counter, periods of fewer than 1600 counts put the switching rate above 50 kHz.

Top module: `dithered_pwm_gen`

## Requirements
- R1: In edge-aligned mode (`center_mode`=0) the shared counter runs 0 to `period`-1, so one PWM period lasts `period` clocks. The high-side output of a phase with applied value 0<v<`period` and dead band d rises d+2 clocks after the first counter cycle of the period.
- R2: In centre-aligned mode (`center_mode`=1, taken at a period boundary) the counter runs up 0..`period`-1 and then down `period`-1..0. A period lasts 2*`period` clocks and the high-side time per period is twice the applied value when no dead band is set.
- R3: A phase accumulates its 8-bit `duty_frac` (value/256) every period. The applied value is `duty_int`+1 on carry-out and `duty_int` otherwise. Over N periods the total applied count differs from N*(`duty_int`+`duty_frac`/256) by at most one count.
- R4: Duty commands are sampled only in the last cycle of a period. A change that is undone before that cycle has no effect on any output.
- R5: The applied value saturates at `period`. A command of `duty_int`>=`period` gives a constantly high high-side output, and 0 with fraction 0 gives a constantly low one.
- R6: At every transition of a phase both outputs are low for `dead_band` clocks, so the high-side time per period is v-d and the low-side time is `period`-v-d. Both outputs are never high together.
- R7: `adc_strobe` is high for exactly one clock per period, in the clock after the counter equals `adc_offset` while counting up. It lies `period`-`adc_offset`+1+d clocks after the previous period's strobe relative to the high-side rise of R1.
- R8: A synchronous active-high `rst` forces all outputs low and clears the counter and accumulators. The first period after reset applies a value of 0 on every phase.
- R9: The three phases are independent. Each follows only its own command fields, at bit offsets p*12 (`duty_int`) and p*8 (`duty_frac`) for phase p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| period | input | 12 | counts per counter ramp, at least 2 |
| center_mode | input | 1 | 1 = triangle counter, 0 = sawtooth |
| adc_offset | input | 12 | up-count value at which the sample strobe fires |
| dead_band | input | 4 | clocks with both outputs low at each transition |
| duty_int | input | 36 | integer duty count, 12 bits per phase |
| duty_frac | input | 24 | fractional duty in 1/256, 8 bits per phase |
| pwm_hi | output | 3 | high-side gate command per phase |
| pwm_lo | output | 3 | low-side gate command per phase |
| adc_strobe | output | 1 | one-clock sample trigger per period |

## Verification
The assertions assume that `period` is at least 2 and holds steady around each period boundary. They also assume that `adc_offset` is below `period`, so the strobe can fire once per period. The stimulus draws random periods, offsets and commands from $urandom with a fixed seed, inside those limits. It places every integer command below the strobe offset so that each measured window holds one complete high-side pulse. Directed cases cover saturation, zero command, dead band, the triangle counter, reset, and a command glitch that is withdrawn before the period ends.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} ramp_dir_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period,
  input  logic          center_mode,
  input  logic [CW-1:0] adc_offset,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          adc_strobe
);
  import pwm_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  ramp_dir_e dir;
  logic      tri_q;
  logic      at_top;

  assign at_top = (cnt >= period - ONE);
  // last cycle of the current period
  assign wrap = tri_q ? (dir == DIR_DOWN && cnt == '0) : at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      dir   <= DIR_UP;
      tri_q <= center_mode;
    end else if (wrap) begin
      cnt   <= '0;
      dir   <= DIR_UP;
      tri_q <= center_mode;
    end else if (!tri_q) begin
      cnt <= cnt + ONE;
    end else if (dir == DIR_UP) begin
      if (at_top) dir <= DIR_DOWN;
      else        cnt <= cnt + ONE;
    end else begin
      cnt <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) adc_strobe <= 1'b0;
    else     adc_strobe <= (dir == DIR_UP) && (cnt == adc_offset);
  end

  // R1: a period end always restarts the ramp from zero counting up
  assert_wrap_restart_R1: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0 && dir == DIR_UP));

  // R7: the strobe is a single-clock pulse
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    adc_strobe |=> !adc_strobe);

  // R2: the down ramp only ever decrements by one
  assert_down_step_R2: assert property (@(posedge clk) disable iff (rst)
    (dir == DIR_DOWN && !wrap) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/pwm_phase.sv
module pwm_phase #(
  parameter int CW  = 12,
  parameter int FW  = 8,
  parameter int DBW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  cnt,
  input  logic           wrap,
  input  logic [CW-1:0]  period,
  input  logic [CW-1:0]  duty_int,
  input  logic [FW-1:0]  duty_frac,
  input  logic [DBW-1:0] dead_band,
  output logic           hi,
  output logic           lo
);
  localparam int SW = FW + 1;
  localparam int WW = CW + 1;

  logic [FW-1:0]  acc;
  logic [SW-1:0]  acc_sum;
  logic [WW-1:0]  want;
  logic [CW-1:0]  cmp_next;
  logic [CW-1:0]  cmp;
  logic           raw_q;
  logic           lvl;
  logic [DBW-1:0] dcnt;

  // first-order sigma-delta: carry-out adds one count this period
  assign acc_sum  = {1'b0, acc} + {1'b0, duty_frac};
  assign want     = {1'b0, duty_int} + WW'(acc_sum[FW]);
  assign cmp_next = (want >= {1'b0, period}) ? period : want[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cmp <= '0;
    end else if (wrap) begin
      acc <= acc_sum[FW-1:0];
      cmp <= cmp_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= 1'b0;
    else     raw_q <= (cnt < cmp);
  end

  // dead band: both outputs low for dead_band clocks at each change
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl  <= 1'b0;
      dcnt <= '0;
      hi   <= 1'b0;
      lo   <= 1'b0;
    end else if (raw_q != lvl) begin
      lvl <= raw_q;
      if (dead_band == '0) begin
        dcnt <= '0;
        hi   <= raw_q;
        lo   <= !raw_q;
      end else begin
        dcnt <= dead_band - DBW'(1);
        hi   <= 1'b0;
        lo   <= 1'b0;
      end
    end else if (dcnt != '0) begin
      dcnt <= dcnt - DBW'(1);
    end else begin
      hi <= lvl;
      lo <= !lvl;
    end
  end

  // R6: never drive both switches of the leg
  assert_no_shoot_R6: assert property (@(posedge clk) disable iff (rst)
    !(hi && lo));

  // R4: the compare value moves only after a period end
  assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrap)) |-> $stable(cmp));

  // R5: the applied value never exceeds the period
  assert_cmp_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrap)) |-> (cmp <= $past(period)));

  // R3: unsaturated commands apply the integer or the integer plus one
  assert_dither_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrap) && ($past(duty_int) < $past(period))) |->
      ({1'b0, cmp} == {1'b0, $past(duty_int)} ||
       {1'b0, cmp} == {1'b0, $past(duty_int)} + WW'(1)));

  // R8: reset forces the leg off
  assert_reset_low_R8: assert property (@(posedge clk)
    rst |=> (!hi && !lo));
endmodule

// File: rtl/dithered_pwm_gen.sv
module dithered_pwm_gen #(
  parameter int NPH = 3,
  parameter int CW  = 12,
  parameter int FW  = 8,
  parameter int DBW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     period,
  input  logic              center_mode,
  input  logic [CW-1:0]     adc_offset,
  input  logic [DBW-1:0]    dead_band,
  input  logic [NPH*CW-1:0] duty_int,
  input  logic [NPH*FW-1:0] duty_frac,
  output logic [NPH-1:0]    pwm_hi,
  output logic [NPH-1:0]    pwm_lo,
  output logic              adc_strobe
);
  logic [CW-1:0] cnt;
  logic          wrap;

  pwm_timebase #(.CW(CW)) u_timebase (
    .clk         (clk),
    .rst         (rst),
    .period      (period),
    .center_mode (center_mode),
    .adc_offset  (adc_offset),
    .cnt         (cnt),
    .wrap        (wrap),
    .adc_strobe  (adc_strobe)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    pwm_phase #(.CW(CW), .FW(FW), .DBW(DBW)) u_phase (
      .clk       (clk),
      .rst       (rst),
      .cnt       (cnt),
      .wrap      (wrap),
      .period    (period),
      .duty_int  (duty_int[p*CW +: CW]),
      .duty_frac (duty_frac[p*FW +: FW]),
      .dead_band (dead_band),
      .hi        (pwm_hi[p]),
      .lo        (pwm_lo[p])
    );
  end
endmodule

// File: tb/test_dithered_pwm_gen.sv
module test_dithered_pwm_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] period = 12'd64;
  logic        center_mode = 1'b0;
  logic [11:0] adc_offset = 12'd50;
  logic [3:0]  dead_band = 4'd0;
  logic [35:0] duty_int = '0;
  logic [23:0] duty_frac = '0;
  logic [2:0]  pwm_hi, pwm_lo;
  logic        adc_strobe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int sum_hi[3], sum_lo[3], min_hi[3], max_hi[3];
  int bad_len, bad_rise, overlap;

  dithered_pwm_gen i_dithered_pwm_gen (
    .clk(clk), .rst(rst), .period(period), .center_mode(center_mode),
    .adc_offset(adc_offset), .dead_band(dead_band), .duty_int(duty_int),
    .duty_frac(duty_frac), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .adc_strobe(adc_strobe)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_near(string tag, real act, real exp, real tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      errors++;
      $display("FAIL %s: actual %f expected %f", tag, act, exp);
    end
  endtask

  task automatic set_duty(int p, int iv, int fv);
    duty_int[p*12 +: 12] = 12'(iv);
    duty_frac[p*8 +: 8]  = 8'(fv);
  endtask

  // measure n strobe-to-strobe windows; rise index tracked on phase 1
  task automatic run_windows(int n, bit sync, int exp_len, int exp_rise);
    int len, ridx;
    int h[3];
    int l[3];
    logic prev1;
    for (int p = 0; p < 3; p++) begin
      sum_hi[p] = 0; sum_lo[p] = 0; min_hi[p] = 1 << 30; max_hi[p] = -1;
    end
    bad_len = 0; bad_rise = 0; overlap = 0;
    if (sync) begin
      do @(negedge clk); while (!adc_strobe);
    end
    prev1 = pwm_hi[1];
    for (int w = 0; w < n; w++) begin
      len = 0; ridx = -1;
      for (int p = 0; p < 3; p++) begin h[p] = 0; l[p] = 0; end
      do begin
        @(negedge clk);
        len++;
        for (int p = 0; p < 3; p++) begin
          h[p] += int'(pwm_hi[p]);
          l[p] += int'(pwm_lo[p]);
        end
        if ((pwm_hi & pwm_lo) != 3'b000) overlap++;
        if (pwm_hi[1] && !prev1) ridx = len;
        prev1 = pwm_hi[1];
      end while (!adc_strobe && len < 2000);
      if (len != exp_len) bad_len++;
      if (exp_rise >= 0 && ridx != exp_rise) bad_rise++;
      for (int p = 0; p < 3; p++) begin
        sum_hi[p] += h[p];
        sum_lo[p] += l[p];
        if (h[p] < min_hi[p]) min_hi[p] = h[p];
        if (h[p] > max_hi[p]) max_hi[p] = h[p];
      end
    end
  endtask

  initial begin
    int pi, oi, iv[3], fv[3];
    void'($urandom(32'h5eed_1234));

    // R8: reset state
    set_duty(0, 23, 102); set_duty(1, 30, 0); set_duty(2, 40, 200);
    repeat (5) @(negedge clk);
    chk("R8 hi low in reset", int'(pwm_hi), 0);
    chk("R8 lo low in reset", int'(pwm_lo), 0);
    chk("R8 strobe low in reset", int'(adc_strobe), 0);
    rst = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (pwm_hi != 3'b000) seen++;
      end
      chk("R8 first period applies zero", seen, 0);
    end

    // R1 R3 R7 R9: edge-aligned dithering over 1000 periods
    run_windows(3, 1'b1, 64, -1);
    run_windows(1000, 1'b0, 64, 15);
    chk("R1 period length", bad_len, 0);
    chk("R7 strobe offset vs rise", bad_rise, 0);
    chk("R6 no overlap edge", overlap, 0);
    chk_near("R3 mean phase0", real'(sum_hi[0]) / 1000.0, 23.0 + 102.0/256.0, 23.4/1000.0);
    chk_near("R3 mean phase2", real'(sum_hi[2]) / 1000.0, 40.0 + 200.0/256.0, 40.8/1000.0);
    chk("R3 min phase0", min_hi[0], 23);
    chk("R3 max phase0", max_hi[0], 24);
    chk("R9 phase1 low", min_hi[1], 30);
    chk("R9 phase1 high", max_hi[1], 30);

    // R4: withdrawn glitch mid-period has no effect
    do @(negedge clk); while (!adc_strobe);
    fork
      begin
        repeat (20) @(negedge clk);
        set_duty(1, 60, 0);
        repeat (15) @(negedge clk);
        set_duty(1, 30, 0);
      end
    join_none
    run_windows(3, 1'b0, 64, 15);
    chk("R4 glitch ignored min", min_hi[1], 30);
    chk("R4 glitch ignored max", max_hi[1], 30);

    // R6: dead band
    dead_band = 4'd5;
    run_windows(3, 1'b1, 64, -1);
    run_windows(40, 1'b0, 64, 20);
    chk("R6 hi time", sum_hi[1], 40 * 25);
    chk("R6 lo time", sum_lo[1], 40 * 29);
    chk("R6 rise delayed", bad_rise, 0);
    chk("R6 no overlap", overlap, 0);
    chk_near("R6 R3 dithered hi time", real'(sum_hi[0]), 40.0 * (23.0 + 102.0/256.0 - 5.0), 1.01);

    // R5: saturation and zero command
    dead_band = 4'd3;
    set_duty(0, 100, 0); set_duty(1, 0, 0); set_duty(2, 64, 255);
    run_windows(3, 1'b1, 64, -1);
    run_windows(10, 1'b0, 64, -1);
    chk("R5 over-range high", sum_hi[0], 640);
    chk("R5 zero low", sum_hi[1], 0);
    chk("R5 zero lo side", sum_lo[1], 640);
    chk("R5 equal period high", sum_hi[2], 640);

    // R2: centre-aligned
    dead_band = 4'd0; period = 12'd50; adc_offset = 12'd30; center_mode = 1'b1;
    set_duty(0, 12, 102); set_duty(1, 20, 0); set_duty(2, 35, 128);
    run_windows(4, 1'b1, 100, -1);
    run_windows(300, 1'b0, 100, -1);
    chk("R2 period length", bad_len, 0);
    chk("R2 phase1 doubled", sum_hi[1], 300 * 40);
    chk_near("R2 R3 mean phase0", real'(sum_hi[0]) / 600.0, 12.0 + 102.0/256.0, 0.02);
    chk_near("R2 R3 mean phase2", real'(sum_hi[2]) / 600.0, 35.5, 0.04);
    center_mode = 1'b0;

    // R3 R7 random edge-aligned configurations
    for (int k = 0; k < 12; k++) begin
      pi = 40 + int'($urandom % 81);
      oi = pi / 2 + int'($urandom % (pi / 2 - 2));
      for (int p = 0; p < 3; p++) begin
        iv[p] = 1 + int'($urandom % (pi / 2 - 3));
        fv[p] = int'($urandom % 256);
        set_duty(p, iv[p], fv[p]);
      end
      period = 12'(pi); adc_offset = 12'(oi);
      run_windows(4, 1'b1, pi, -1);
      run_windows(25, 1'b0, pi, pi - oi + 1);
      chk("R1 random period", bad_len, 0);
      chk("R7 random strobe", bad_rise, 0);
      for (int p = 0; p < 3; p++) begin
        chk_near("R3 random total", real'(sum_hi[p]),
                 25.0 * (real'(iv[p]) + real'(fv[p]) / 256.0), 1.01);
      end
    end

    // R8: reset mid-run
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 outputs low mid-run reset", int'(pwm_hi | pwm_lo), 0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule